// File: doc/BRIEF.md
# Procedure Call Frame Sequencer

This block carries out a complex subroutine call as a multi-cycle hardware sequence. A single start pulse brings in the caller's stack pointer, frame pointer, argument count, return PC, call target and a 12-bit register save mask. The save mask belongs to the called procedure and arrives with the target. The sequencer then builds an activation record on a downward-growing memory stack of 4-byte words. It uses a write port that takes one word per cycle. Register values come from a register-file read port with combinational read data.

The fixed order of the sequence is as follows. The stack pointer is aligned. The argument count is written. Each register selected by the mask is saved. The return address, the caller's stack-top pointer and the caller's frame-base pointer follow. The condition codes are cleared. A status word and a zero word are written. Finally the new stack pointer, frame pointer and program counter are presented together with a done pulse.

States: `S_IDLE`, `S_ALIGN`, `S_ARGC`, `S_REGS`, `S_RET`, `S_SPTOP`, `S_FPBASE`, `S_CCLR`, `S_STATUS`, `S_ZERO`, `S_DONE`.

Transitions:
- `S_IDLE` moves to `S_ALIGN` on start. Otherwise it stays in `S_IDLE`.
- `S_ALIGN` moves to `S_ARGC`.
- `S_ARGC` moves to `S_REGS` when the mask is non-zero. Otherwise it moves to `S_RET`.
- `S_REGS` stays in `S_REGS` while selected registers remain. It moves to `S_RET` after the last one.
- From `S_RET` the sequence runs `S_SPTOP`, `S_FPBASE`, `S_CCLR`, `S_STATUS`, `S_ZERO`, `S_DONE`, and then returns to `S_IDLE`.

Top module: `call_frame_seq`

## Requirements
- R1: Alignment rounds the incoming stack pointer down to a multiple of 4. It takes one cycle with no write. The first write therefore occurs two cycles after start is sampled, at address (sp & ~3) - 4.
- R2: The first word written is the argument count, zero-extended to 32 bits.
- R3: Registers whose mask bit is set are saved in ascending register number, one per cycle, in back-to-back cycles. During each save, rf_raddr carries the register number. A register with a clear mask bit takes no cycle.
- R4: After the saved registers come three words in consecutive cycles: the return PC, then the caller's unaligned stack pointer, then the caller's frame pointer.
- R5: In the cycle after the frame-pointer write, cc_clear pulses high for exactly one cycle with no memory write.
- R6: The cycle after cc_clear writes the status word. Bits 1:0 hold the two low bits of the incoming stack pointer, bits 27:16 hold the save mask, and all other bits are zero. The next cycle writes a zero word.
- R7: done is a one-cycle pulse in the cycle after the zero-word write. While done is high, sp_out and fp_out both equal the address of the zero word and pc_out equals the target. These values are held until the next call completes.
- R8: Every write address is word aligned and 4 below the previous write of the same call. mem_we is only ever high while busy.
- R9: A start pulse is ignored while busy, including in the done cycle. It does not change the frame being built and does not begin a new call.
- R10: After reset, busy, mem_we, cc_clear and done are low, and sp_out, fp_out and pc_out are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Call request, sampled in idle |
| sp_in | input | 32 | Caller stack pointer |
| fp_in | input | 32 | Caller frame pointer |
| argc_in | input | 8 | Argument count |
| ret_pc_in | input | 32 | Return address |
| target_in | input | 32 | Call target address |
| save_mask_in | input | 12 | Callee register save mask, bit i selects register i |
| rf_raddr | output | 4 | Register-file read address |
| rf_rdata | input | 32 | Register-file read data, combinational |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | 32 | Stack write address |
| mem_wdata | output | 32 | Stack write data |
| cc_clear | output | 1 | Clear condition codes pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| sp_out | output | 32 | New stack pointer |
| fp_out | output | 32 | New frame pointer |
| pc_out | output | 32 | New program counter |

## Verification
The assertions assume two things about the environment. Reset is applied from time zero. The register file answers the read address within the same cycle, so that the sampled write data belongs to the register named in that cycle. The bench keeps within both assumptions: it holds reset before the first edge, and it models the register file as a combinational function of rf_raddr. It drives start only at falling edges, with call arguments stable for the whole pulse. It uses mixed masks, including empty and full ones, and stack pointers with every low-bit offset. It also pulses start mid-call and in the done cycle.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ALIGN,
        S_ARGC,
        S_REGS,
        S_RET,
        S_SPTOP,
        S_FPBASE,
        S_CCLR,
        S_STATUS,
        S_ZERO,
        S_DONE
    } cfs_state_e;

    localparam int STATUS_MASK_LSB = 16;
endpackage

// File: rtl/cfs_lowbit.sv
module cfs_lowbit #(
    parameter int N = 12,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx    = IW'(i);
                onehot = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/cfs_sp_unit.sv
module cfs_sp_unit #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            align,
    input  logic            dec,
    input  logic [XLEN-1:0] sp_in,
    output logic [XLEN-1:0] sp_q,
    output logic [XLEN-1:0] push_addr
);
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

    assign push_addr = sp_q - WORD_BYTES;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (load) begin
            sp_q <= sp_in;
        end else if (align) begin
            sp_q <= {sp_q[XLEN-1:2], 2'b00};
        end else if (dec) begin
            sp_q <= push_addr;
        end
    end
endmodule

// File: rtl/call_frame_seq.sv
module call_frame_seq
    import cfs_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 12,
    parameter int ACW   = 8,
    localparam int RIW  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [XLEN-1:0]  sp_in,
    input  logic [XLEN-1:0]  fp_in,
    input  logic [ACW-1:0]   argc_in,
    input  logic [XLEN-1:0]  ret_pc_in,
    input  logic [XLEN-1:0]  target_in,
    input  logic [NREGS-1:0] save_mask_in,
    output logic [RIW-1:0]   rf_raddr,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    output logic             cc_clear,
    output logic             busy,
    output logic             done,
    output logic [XLEN-1:0]  sp_out,
    output logic [XLEN-1:0]  fp_out,
    output logic [XLEN-1:0]  pc_out
);
    cfs_state_e state_q, state_d;

    logic [ACW-1:0]   argc_q;
    logic [XLEN-1:0]  ret_q, sptop_q, fp_q, tgt_q;
    logic [NREGS-1:0] mask_q, rem_q, rem_onehot, rem_after;
    logic [1:0]       low2_q;
    logic [XLEN-1:0]  sp_cur, push_addr, status_word;
    logic [RIW-1:0]   scan_idx;
    logic             accept;

    assign accept    = (state_q == S_IDLE) && start;
    assign busy      = (state_q != S_IDLE);
    assign rem_after = rem_q & ~rem_onehot;
    assign rf_raddr  = scan_idx;
    assign mem_addr  = push_addr;

    cfs_lowbit #(.N(NREGS)) u_scan (
        .vec    (rem_q),
        .idx    (scan_idx),
        .onehot (rem_onehot)
    );

    cfs_sp_unit #(.XLEN(XLEN)) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .align     (state_q == S_ALIGN),
        .dec       (mem_we),
        .sp_in     (sp_in),
        .sp_q      (sp_cur),
        .push_addr (push_addr)
    );

    always_comb begin
        status_word = '0;
        status_word[1:0] = low2_q;
        status_word[STATUS_MASK_LSB +: NREGS] = mask_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_ALIGN;
            S_ALIGN:  state_d = S_ARGC;
            S_ARGC:   state_d = (mask_q == '0) ? S_RET : S_REGS;
            S_REGS:   if (rem_after == '0) state_d = S_RET;
            S_RET:    state_d = S_SPTOP;
            S_SPTOP:  state_d = S_FPBASE;
            S_FPBASE: state_d = S_CCLR;
            S_CCLR:   state_d = S_STATUS;
            S_STATUS: state_d = S_ZERO;
            S_ZERO:   state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = '0;
        cc_clear  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_ARGC:   begin mem_we = 1'b1; mem_wdata = XLEN'(argc_q); end
            S_REGS:   begin mem_we = 1'b1; mem_wdata = rf_rdata;      end
            S_RET:    begin mem_we = 1'b1; mem_wdata = ret_q;         end
            S_SPTOP:  begin mem_we = 1'b1; mem_wdata = sptop_q;       end
            S_FPBASE: begin mem_we = 1'b1; mem_wdata = fp_q;          end
            S_CCLR:   cc_clear = 1'b1;
            S_STATUS: begin mem_we = 1'b1; mem_wdata = status_word;   end
            S_ZERO:   begin mem_we = 1'b1; mem_wdata = '0;            end
            S_DONE:   done = 1'b1;
            default:  ;
        endcase
    end

    // call operands and register scan
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            argc_q  <= '0;
            ret_q   <= '0;
            sptop_q <= '0;
            fp_q    <= '0;
            tgt_q   <= '0;
            mask_q  <= '0;
            rem_q   <= '0;
            low2_q  <= '0;
        end else if (accept) begin
            argc_q  <= argc_in;
            ret_q   <= ret_pc_in;
            sptop_q <= sp_in;
            fp_q    <= fp_in;
            tgt_q   <= target_in;
            mask_q  <= save_mask_in;
            rem_q   <= save_mask_in;
            low2_q  <= sp_in[1:0];
        end else if (state_q == S_REGS) begin
            rem_q   <= rem_after;
        end
    end

    // results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_out <= '0;
            fp_out <= '0;
            pc_out <= '0;
        end else if (state_q == S_ZERO) begin
            sp_out <= push_addr;
            fp_out <= push_addr;
            pc_out <= tgt_q;
        end
    end

    // assertions
    assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[1:0] == 2'b00));

    assert_write_descends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - XLEN'(4)));

    assert_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_reg_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REGS && $past(state_q) == S_REGS) |-> (rf_raddr > $past(rf_raddr)));

    assert_cc_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cc_clear |-> (!mem_we && $past(mem_we)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ptrs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sp_out == fp_out && sp_out == $past(mem_addr)));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/call_frame_seq_bench.sv
module call_frame_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] sp_in = '0, fp_in = '0, ret_pc_in = '0, target_in = '0;
    logic [7:0]  argc_in = '0;
    logic [11:0] save_mask_in = '0;
    logic [3:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        mem_we, cc_clear, busy, done;
    logic [31:0] mem_addr, mem_wdata, sp_out, fp_out, pc_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // write log
    logic [31:0] lg_addr [0:31];
    logic [31:0] lg_data [0:31];
    int          lg_cyc  [0:31];
    int          lg_n = 0;
    int          cc_n = 0, cc_cyc = 0;
    int          dn_n = 0, dn_cyc = 0;
    logic [31:0] dn_sp, dn_fp, dn_pc;

    always #4 clk = ~clk;

    function automatic logic [31:0] regval(input logic [3:0] r);
        return 32'hC0DE_0000 + 32'(r) * 32'h0000_0111 + 32'(r) * 32'h0101_0000;
    endfunction

    assign rf_rdata = regval(rf_raddr);

    call_frame_seq u_call_frame_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sp_in(sp_in), .fp_in(fp_in), .argc_in(argc_in),
        .ret_pc_in(ret_pc_in), .target_in(target_in), .save_mask_in(save_mask_in),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cc_clear(cc_clear), .busy(busy), .done(done),
        .sp_out(sp_out), .fp_out(fp_out), .pc_out(pc_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not complete (actual cycle %0d, expected < 150000)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (mem_we && lg_n < 32) begin
            lg_addr[lg_n] = mem_addr;
            lg_data[lg_n] = mem_wdata;
            lg_cyc[lg_n]  = cyc;
            lg_n = lg_n + 1;
        end
        if (cc_clear) begin cc_n = cc_n + 1; cc_cyc = cyc; end
        if (done) begin
            dn_n = dn_n + 1; dn_cyc = cyc;
            dn_sp = sp_out; dn_fp = fp_out; dn_pc = pc_out;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        lg_n = 0; cc_n = 0; dn_n = 0;
    endtask

    task automatic pulse_start(input logic [31:0] sp, input logic [31:0] fp, input logic [7:0] ac,
                               input logic [31:0] rp, input logic [31:0] tg, input logic [11:0] m);
        sp_in = sp; fp_in = fp; argc_in = ac; ret_pc_in = rp; target_in = tg; save_mask_in = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 200; k++) begin
            if (done) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    // compare the logged frame of one call with the expected frame
    task automatic check_frame(input int s_cyc, input logic [31:0] sp, input logic [31:0] fp,
                               input logic [7:0] ac, input logic [31:0] rp, input logic [31:0] tg,
                               input logic [11:0] m);
        logic [31:0] ea [0:31];
        logic [31:0] ed [0:31];
        string       et [0:31];
        int          n = 0;
        int          nr;
        logic [31:0] base;
        base = {sp[31:2], 2'b00};
        ed[n] = 32'(ac); et[n] = "R2 argc"; n++;
        for (int r = 0; r < 12; r++) begin
            if (m[r]) begin ed[n] = regval(4'(r)); et[n] = "R3 saved reg"; n++; end
        end
        nr = n - 1;
        ed[n] = rp; et[n] = "R4 return pc"; n++;
        ed[n] = sp; et[n] = "R4 stack top"; n++;
        ed[n] = fp; et[n] = "R4 frame base"; n++;
        ed[n] = (32'(m) << 16) | 32'(sp[1:0]); et[n] = "R6 status"; n++;
        ed[n] = 32'h0; et[n] = "R6 zero word"; n++;
        for (int i = 0; i < n; i++) ea[i] = base - 32'(4 * (i + 1));

        chk(lg_n == n, "R8 write count", 32'(lg_n), 32'(n));
        if (lg_n >= 1) chk(lg_cyc[0] == s_cyc + 2, "R1 first write cycle", 32'(lg_cyc[0]), 32'(s_cyc + 2));
        for (int i = 0; i < n && i < lg_n; i++) begin
            chk(lg_addr[i] == ea[i], (i == 0) ? "R1 aligned address" : "R8 address", lg_addr[i], ea[i]);
            chk(lg_data[i] == ed[i], et[i], lg_data[i], ed[i]);
            if (i <= nr + 3)
                chk(lg_cyc[i] == s_cyc + 2 + i, "R3 write cycle", 32'(lg_cyc[i]), 32'(s_cyc + 2 + i));
        end
        chk(cc_n == 1, "R5 cc_clear count", 32'(cc_n), 32'd1);
        chk(cc_cyc == s_cyc + 6 + nr, "R5 cc_clear cycle", 32'(cc_cyc), 32'(s_cyc + 6 + nr));
        if (lg_n == n) begin
            chk(lg_cyc[n-2] == cc_cyc + 1, "R6 status cycle", 32'(lg_cyc[n-2]), 32'(cc_cyc + 1));
            chk(lg_cyc[n-1] == cc_cyc + 2, "R6 zero cycle", 32'(lg_cyc[n-1]), 32'(cc_cyc + 2));
        end
        chk(dn_n == 1, "R7 done count", 32'(dn_n), 32'd1);
        chk(dn_cyc == s_cyc + 9 + nr, "R7 done cycle", 32'(dn_cyc), 32'(s_cyc + 9 + nr));
        chk(dn_sp == ea[n-1], "R7 sp_out", dn_sp, ea[n-1]);
        chk(dn_fp == ea[n-1], "R7 fp_out", dn_fp, ea[n-1]);
        chk(dn_pc == tg, "R7 pc_out", dn_pc, tg);
        chk(sp_out == ea[n-1] && pc_out == tg, "R7 held after done", sp_out, ea[n-1]);
    endtask

    task automatic t_call(input logic [31:0] sp, input logic [31:0] fp, input logic [7:0] ac,
                          input logic [31:0] rp, input logic [31:0] tg, input logic [11:0] m);
        int s;
        clear_log();
        s = cyc;
        pulse_start(sp, fp, ac, rp, tg, m);
        wait_done();
        check_frame(s, sp, fp, ac, rp, tg, m);
    endtask

    task automatic t_reset();
        chk(!busy, "R10 busy", 32'(busy), 32'd0);
        chk(!mem_we, "R10 mem_we", 32'(mem_we), 32'd0);
        chk(!cc_clear, "R10 cc_clear", 32'(cc_clear), 32'd0);
        chk(!done, "R10 done", 32'(done), 32'd0);
        chk(sp_out == 0 && fp_out == 0, "R10 pointers", sp_out | fp_out, 32'd0);
        chk(pc_out == 0, "R10 pc_out", pc_out, 32'd0);
    endtask

    // R9: start pulses mid-call and in the done cycle are ignored
    task automatic t_ignore();
        int s;
        clear_log();
        s = cyc;
        pulse_start(32'h0000_8003, 32'h0000_9000, 8'd5, 32'h0000_1234, 32'h0000_4000, 12'h0A5);
        @(negedge clk);
        pulse_start(32'h0000_0F00, 32'h1111_1111, 8'd77, 32'h2222_2222, 32'h3333_3333, 12'hFFF);
        sp_in = 32'h0000_8003; fp_in = 32'h0000_9000; argc_in = 8'd5;
        ret_pc_in = 32'h0000_1234; target_in = 32'h0000_4000; save_mask_in = 12'h0A5;
        for (int k = 0; k < 200; k++) begin
            if (done) break;
            @(negedge clk);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_frame(s, 32'h0000_8003, 32'h0000_9000, 8'd5, 32'h0000_1234, 32'h0000_4000, 12'h0A5);
        repeat (4) @(negedge clk);
        chk(!busy, "R9 no call from start in done cycle", 32'(busy), 32'd0);
        chk(lg_n == 10, "R9 no extra writes", 32'(lg_n), 32'd10);
        chk(dn_n == 1, "R9 single done", 32'(dn_n), 32'd1);
    endtask

    task automatic t_random(input int count);
        for (int k = 0; k < count; k++) begin
            logic [31:0] sp;
            logic [11:0] m;
            sp = 32'h0001_0000 + ($urandom() & 32'h0000_FFFF);
            m  = 12'($urandom());
            t_call(sp, $urandom(), 8'($urandom()), $urandom(), $urandom(), m);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_call(32'h0000_2000, 32'h0000_3000, 8'd0,   32'h0000_0100, 32'h0000_0800, 12'h000);
        t_call(32'h0000_2003, 32'h0000_3010, 8'd255, 32'hDEAD_BEEF, 32'hCAFE_0000, 12'hFFF);
        t_call(32'h0000_4001, 32'h0000_5000, 8'd3,   32'h0000_0200, 32'h0000_0A00, 12'h800);
        t_call(32'h0000_4002, 32'h0000_5004, 8'd1,   32'h0000_0300, 32'h0000_0B00, 12'h001);
        t_ignore();
        t_random(20);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule